// File: doc/BRIEF.md
# Serial CRC-32 Engine with Residue Check

This block computes a 32-bit cyclic redundancy code over a bit stream that arrives one bit per clock. Each accepted bit is folded into the top of the running remainder right at the feedback decision. The engine therefore needs no warm-up cycles before the first bit. It also needs no zero-bit flush at the end, because no room has to be made for the code. The bit order is fixed at elaboration. In the forward order the remainder shifts toward its most significant bit. In the reflected order it shifts toward bit 0 and uses the bit-reversed generator.

The same engine generates and checks. A transmitter seeds the remainder, streams the message, and then appends `crc_o`, the bitwise inverse of the remainder. A receiver streams the message and the appended code through an identical engine and raises `finish_i`. One cycle later `check_ok_o` reports whether the remainder has landed on the fixed residue that every intact frame leaves behind. The receiver never recomputes the code and compares it.

The bit input is a valid/ready stream. A bit moves on a clock edge where `bit_valid_i` and `bit_ready_o` are both high. `bit_ready_o` drops only while `start_i` is high. A source that sees ready low must hold its bit and retry on a later cycle. `start_i` and `finish_i` are plain control strobes.

Top module: `bitcrc_engine`

## Requirements
- R1: During and after a synchronous reset, `remainder_o` is 0xFFFFFFFF, `crc_o` is 0 and `check_ok_o` is 0.
- R2: `start_i` reloads the remainder with all ones on the next edge. While `start_i` is high, `bit_ready_o` is low and a bit offered in that cycle is discarded.
- R3: With REFLECT=0, an accepted bit is XORed into remainder bit 31. If that bit is then 1, the remainder is shifted left one place and XORed with POLY (default 0x04C11DB7). Otherwise it is only shifted left. Bytes are fed bit 7 first, so the ASCII string "123456789" yields `crc_o` = 0xFC891918.
- R4: With REFLECT=1, an accepted bit is XORed into remainder bit 0. If that bit is then 1, the remainder is shifted right one place and XORed with POLY (default 0xEDB88320). Otherwise it is only shifted right. Bytes are fed bit 0 first, so "123456789" yields `crc_o` = 0xCBF43926.
- R5: In a cycle where `bit_valid_i` is low, the remainder keeps its value whatever `bit_i` holds.
- R6: `crc_o` is always the bitwise inverse of `remainder_o`. An empty message gives 0, and a message of a single zero bit gives a nonzero code, because of the all-ones seed.
- R7: A message followed by its `crc_o` leaves the remainder at the residue: 0xC704DD7B with REFLECT=0, or 0xDEBB20E3 with REFLECT=1. With REFLECT=0 the code is appended bit 31 first; with REFLECT=1 it is appended bit 0 first. `check_ok_o` is then 1 in the cycle after `finish_i`.
- R8: `check_ok_o` is 1 only in a cycle that directly follows a cycle with `finish_i` high. It is 0 after a finish whose remainder differs from the residue, for example when one bit of the appended code is flipped.
- R9: A bit accepted in the same cycle as `finish_i` is included in the value compared against the residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Reload the all-ones seed |
| bit_valid_i | input | 1 | `bit_i` holds a bit to consume |
| bit_ready_o | output | 1 | Engine can take a bit this cycle |
| bit_i | input | 1 | Serial data bit |
| finish_i | input | 1 | End of frame: compare against the residue |
| remainder_o | output | 32 | Running remainder |
| crc_o | output | 32 | Inverted remainder, ready to append |
| check_ok_o | output | 1 | Residue matched at the last finish (one cycle) |

## Verification
Every one-byte message is swept in both bit orders. Each result is compared with a bench-side bit-at-a-time model. The swept code is then appended and the frame must reach the residue and raise the check flag. Half of the appends end with the finish strobe on the last bit, which separates a same-cycle merge from a one-cycle-late compare. The well-known nine-character check string pins each bit order and default polynomial to published values, so a swapped shift direction or an unreflected polynomial shows up. Further patterns cover the following:
- the empty frame and a lone zero bit, which separate an all-ones seed from a zero seed;
- idle cycles with the data line toggling, which expose a bit taken without valid;
- a start that collides with a valid bit;
- a corrupted appended code, which must leave the flag low.

// File: rtl/bitcrc_pkg.sv
package bitcrc_pkg;
  localparam int CRC_W = 32;
  typedef logic [CRC_W-1:0] rem_t;

  // One feedback step with the input merged at the decision point.
  function automatic rem_t advance(rem_t r, logic d, rem_t poly, bit reflect);
    logic fb;
    rem_t n;
    if (reflect) begin
      fb = r[0] ^ d;
      n  = r >> 1;
    end else begin
      fb = r[CRC_W-1] ^ d;
      n  = r << 1;
    end
    if (fb) n = n ^ poly;
    return n;
  endfunction

  // Residue of an intact frame: all ones pushed through CRC_W zero steps.
  function automatic rem_t residue_of(rem_t poly, bit reflect);
    rem_t r;
    r = '1;
    for (int i = 0; i < CRC_W; i++) r = advance(r, 1'b0, poly, reflect);
    return r;
  endfunction
endpackage

// File: rtl/bitcrc_step.sv
module bitcrc_step
  import bitcrc_pkg::*;
#(
  parameter bit   REFLECT = 1'b0,
  parameter rem_t POLY    = 32'h04C11DB7
) (
  input  rem_t cur_i,
  input  logic din_i,
  output rem_t nxt_o
);
  localparam int TOP = CRC_W - 1;
  logic fb;
  rem_t shifted;

  generate
    if (REFLECT) begin : g_lsb_first
      assign fb      = cur_i[0] ^ din_i;
      assign shifted = {1'b0, cur_i[TOP:1]};
    end else begin : g_msb_first
      assign fb      = cur_i[TOP] ^ din_i;
      assign shifted = {cur_i[TOP-1:0], 1'b0};
    end
  endgenerate

  assign nxt_o = fb ? (shifted ^ POLY) : shifted;
endmodule

// File: rtl/bitcrc_state.sv
module bitcrc_state
  import bitcrc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_seed_i,
  input  rem_t d_i,
  output rem_t q_o
);
  always_ff @(posedge clk) begin
    if (rst || load_seed_i) q_o <= '1;
    else                    q_o <= d_i;
  end
endmodule

// File: rtl/bitcrc_verdict.sv
module bitcrc_verdict
  import bitcrc_pkg::*;
#(
  parameter rem_t RESIDUE = 32'hC704DD7B
) (
  input  logic clk,
  input  logic rst,
  input  logic finish_i,
  input  rem_t cand_i,
  output logic ok_o
);
  always_ff @(posedge clk) begin
    if (rst) ok_o <= 1'b0;
    else     ok_o <= finish_i && (cand_i == RESIDUE);
  end
endmodule

// File: rtl/bitcrc_engine.sv
module bitcrc_engine
  import bitcrc_pkg::*;
#(
  parameter bit   REFLECT = 1'b0,
  parameter rem_t POLY    = REFLECT ? 32'hEDB88320 : 32'h04C11DB7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             bit_valid_i,
  output logic             bit_ready_o,
  input  logic             bit_i,
  input  logic             finish_i,
  output logic [CRC_W-1:0] remainder_o,
  output logic [CRC_W-1:0] crc_o,
  output logic             check_ok_o
);
  localparam rem_t RESIDUE = residue_of(POLY, REFLECT);

  rem_t rem_q;
  rem_t stepped;
  rem_t rem_d;
  logic take;

  assign bit_ready_o = !start_i;
  assign take        = bit_valid_i && bit_ready_o;

  bitcrc_step #(.REFLECT(REFLECT), .POLY(POLY)) u_step (
    .cur_i (rem_q),
    .din_i (bit_i),
    .nxt_o (stepped)
  );

  assign rem_d = take ? stepped : rem_q;

  bitcrc_state u_state (
    .clk         (clk),
    .rst         (rst),
    .load_seed_i (start_i),
    .d_i         (rem_d),
    .q_o         (rem_q)
  );

  bitcrc_verdict #(.RESIDUE(RESIDUE)) u_verdict (
    .clk      (clk),
    .rst      (rst),
    .finish_i (finish_i),
    .cand_i   (rem_d),
    .ok_o     (check_ok_o)
  );

  assign remainder_o = rem_q;
  assign crc_o       = ~rem_q;
endmodule

// File: rtl/bitcrc_engine_chk.sv
module bitcrc_engine_chk
  import bitcrc_pkg::*;
#(
  parameter bit   REFLECT = 1'b0,
  parameter rem_t POLY    = 32'h04C11DB7
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             bit_valid_i,
  input logic             finish_i,
  input logic [CRC_W-1:0] remainder_o,
  input logic             check_ok_o
);
  localparam rem_t RESIDUE = residue_of(POLY, REFLECT);

  assert_seed_load_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (remainder_o == '1));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !bit_valid_i) |=> $stable(remainder_o));

  assert_flag_at_residue_R7: assert property (@(posedge clk) disable iff (rst)
    check_ok_o |-> (remainder_o == RESIDUE));

  assert_flag_needs_finish_R8: assert property (@(posedge clk) disable iff (rst)
    !finish_i |=> !check_ok_o);
endmodule

bind bitcrc_engine bitcrc_engine_chk #(.REFLECT(REFLECT), .POLY(POLY)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .bit_valid_i (bit_valid_i),
  .finish_i    (finish_i),
  .remainder_o (remainder_o),
  .check_ok_o  (check_ok_o)
);

// File: tb/sim_bitcrc_engine.sv
module sim_bitcrc_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] start_s  = '0;
  logic [1:0] valid_s  = '0;
  logic [1:0] bit_s    = '0;
  logic [1:0] finish_s = '0;
  logic [1:0] ready_s;
  logic [1:0] ok_s;
  logic [31:0] rem_s [2];
  logic [31:0] crc_s [2];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bitcrc_engine #(.REFLECT(1'b0)) u0 (
    .clk(clk), .rst(rst), .start_i(start_s[0]), .bit_valid_i(valid_s[0]),
    .bit_ready_o(ready_s[0]), .bit_i(bit_s[0]), .finish_i(finish_s[0]),
    .remainder_o(rem_s[0]), .crc_o(crc_s[0]), .check_ok_o(ok_s[0]));

  bitcrc_engine #(.REFLECT(1'b1)) u1 (
    .clk(clk), .rst(rst), .start_i(start_s[1]), .bit_valid_i(valid_s[1]),
    .bit_ready_o(ready_s[1]), .bit_i(bit_s[1]), .finish_i(finish_s[1]),
    .remainder_o(rem_s[1]), .crc_o(crc_s[1]), .check_ok_o(ok_s[1]));

  // Independent bench model: bit-at-a-time division with merged input.
  function automatic logic [31:0] mdl(logic [31:0] r, logic b, int m);
    logic [31:0] x;
    if (m == 0) begin
      x = r ^ ({31'd0, b} << 31);
      return x[31] ? ((x << 1) ^ 32'h04C11DB7) : (x << 1);
    end
    x = r ^ {31'd0, b};
    return x[0] ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
  endfunction

  function automatic logic [31:0] residue_exp(int m);
    return (m == 0) ? 32'hC704DD7B : 32'hDEBB20E3;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic send_bit(int m, logic b, logic fin);
    valid_s[m] = 1'b1; bit_s[m] = b; finish_s[m] = fin;
    @(negedge clk);
    valid_s[m] = 1'b0; finish_s[m] = 1'b0;
  endtask

  task automatic do_start(int m);
    start_s[m] = 1'b1;
    @(negedge clk);
    start_s[m] = 1'b0;
  endtask

  task automatic do_finish(int m);
    finish_s[m] = 1'b1;
    @(negedge clk);
    finish_s[m] = 1'b0;
  endtask

  task automatic send_byte(int m, logic [7:0] v, inout logic [31:0] model);
    for (int i = 0; i < 8; i++) begin
      logic b;
      b = (m == 0) ? v[7-i] : v[i];
      send_bit(m, b, 1'b0);
      model = mdl(model, b, m);
    end
  endtask

  // Append a code in the mode's order; optionally finish on the last bit.
  task automatic send_code(int m, logic [31:0] c, logic fin_last);
    for (int i = 0; i < 32; i++) begin
      logic b;
      b = (m == 0) ? c[31-i] : c[i];
      send_bit(m, b, (i == 31) && fin_last);
    end
    if (!fin_last) do_finish(m);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] model;
    logic [31:0] held;
    logic [31:0] code;
    @(negedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R1 reset remainder", rem_s[m], 32'hFFFFFFFF);
      chk("R1 reset crc", crc_s[m], 32'h0);
      chk("R1 reset flag", {31'd0, ok_s[m]}, 32'h0);
    end
    rst = 1'b0;
    @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      // R6: empty frame and a lone zero bit
      do_start(m);
      chk("R6 empty frame code", crc_s[m], 32'h0);
      send_bit(m, 1'b0, 1'b0);
      model = mdl(32'hFFFFFFFF, 1'b0, m);
      chk("R6 single zero bit code", crc_s[m], ~model);
      checks++;
      if (crc_s[m] == 32'h0) begin
        fails++;
        $display("FAIL R6 zero bit not detected: actual %08h expected nonzero", crc_s[m]);
      end

      // R5: bit line toggling without valid
      held = rem_s[m];
      for (int k = 0; k < 4; k++) begin
        bit_s[m] = k[0];
        @(negedge clk);
      end
      chk("R5 invalid bits ignored", rem_s[m], held);

      // R2: start collides with a valid bit
      start_s[m] = 1'b1; valid_s[m] = 1'b1; bit_s[m] = 1'b1;
      #1;
      chk("R2 ready low under start", {31'd0, ready_s[m]}, 32'h0);
      @(negedge clk);
      start_s[m] = 1'b0; valid_s[m] = 1'b0;
      chk("R2 seed wins over bit", rem_s[m], 32'hFFFFFFFF);
      #1;
      chk("R2 ready back high", {31'd0, ready_s[m]}, 32'h1);

      // R3/R4: published check string
      do_start(m);
      model = 32'hFFFFFFFF;
      for (int c = 0; c < 9; c++) send_byte(m, 8'h31 + 8'(c), model);
      chk(m == 0 ? "R3 check string" : "R4 check string", crc_s[m],
          m == 0 ? 32'hFC891918 : 32'hCBF43926);

      // Sweep all one-byte messages
      for (int v = 0; v < 256; v++) begin
        do_start(m);
        model = 32'hFFFFFFFF;
        send_byte(m, 8'(v), model);
        chk(m == 0 ? "R3 byte sweep" : "R4 byte sweep", crc_s[m], ~model);
        chk("R6 inverse relation", crc_s[m], ~rem_s[m]);
        code = crc_s[m];
        do_finish(m);
        chk("R8 flag on bare message", {31'd0, ok_s[m]},
            {31'd0, (model == residue_exp(m))});
        send_code(m, code, v[0]);
        chk(v[0] ? "R9 finish with last bit" : "R7 frame check flag",
            {31'd0, ok_s[m]}, 32'h1);
        chk("R7 residue value", rem_s[m], residue_exp(m));
        @(negedge clk);
        chk("R8 flag is one cycle", {31'd0, ok_s[m]}, 32'h0);
      end

      // R8: corrupted appended code
      for (int v = 0; v < 32; v++) begin
        do_start(m);
        model = 32'hFFFFFFFF;
        send_byte(m, 8'(v * 7), model);
        code = crc_s[m] ^ (32'h1 << v);
        send_code(m, code, 1'b0);
        chk("R8 corrupted code rejected", {31'd0, ok_s[m]}, 32'h0);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule